// File: doc/BRIEF.md
# Idle-Locked Serial Descrambler

This block sits in a 100 Mb/s receive path. It takes one scrambled line bit at a time and turns it back into plain data by XORing each bit with a key bit from a local 11-bit key generator. That generator must run in step with the one at the far end. The block gets into step on its own by watching the line while the far end sends scrambled idle, which is all ones before scrambling. During that time each received bit is inverted and shifted into the key register. This fills the register with the far end's key. Once 60 descrambled ones in a row have been seen, the block declares lock and the key generator runs free.

While locked, a hold timer runs. Each time the block sees a run of 58 consecutive descrambled ones, the timer restarts. If the timer's period runs out first, the block drops lock, pulses a lock-lost flag, clears its key register and goes back to acquiring. The output is an unaligned bit stream: finding code-group boundaries and decoding symbols are done by blocks further down the path. The timer length is a parameter, so a bench can use a short period.

Top module: `idle_descrambler`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, locked, lock_lost and plain_bit are all 0. The key register is cleared to zero.
- R2: The key follows k[n] = k[n-11] XOR k[n-9], which is the polynomial x^11 + x^9 + 1. The key register holds the last 11 key values, with the newest at the low end. On each clock edge with bit_en high, plain_bit becomes scr_bit XOR k[n] and the key register advances by one place. While locked, plain_bit equals the transmitted data bit.
- R3: While unlocked, the inverse of each received bit is shifted into the key register. After 11 bits of scrambled idle, the register therefore holds the far end's key.
- R4: locked rises at the clock edge of the bit_en tick that completes 60 consecutive descrambled ones. From reset, with the line held at all ones (a zero key), this is exactly the 60th bit. With any other far-end key, it is between the 60th and the 71st bit.
- R5: While locked, received bits are not loaded into the key register. A single corrupted line bit therefore makes exactly one plain_bit wrong, and the bits after it are correct.
- R6: The hold timer starts from zero at the lock tick and counts bit_en ticks only. If it is never restarted, locked falls at the HOLD_CYCLES-th tick after lock.
- R7: The tick that completes 58 consecutive descrambled ones restarts the hold period, and this restart takes priority over expiry in the same tick. The run counter clears at lock, at each restart and on any descrambled zero.
- R8: When the hold period expires, lock_lost is high for exactly one clock, on the same edge where locked falls. The key register is cleared and acquisition starts again, so regaining lock needs a new run of 60 ones.
- R9: A clock edge with bit_en low changes neither plain_bit, locked, the key nor the hold timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies scr_bit for the current clock edge |
| scr_bit | input | 1 | Scrambled line bit |
| plain_bit | output | 1 | Descrambled bit, registered |
| locked | output | 1 | High while the key generator is in step with the far end |
| lock_lost | output | 1 | One-clock pulse when lock is dropped by hold-timer expiry |

## Verification
A key register that is out of step shows at the ports within one tick: plain_bit stops matching the data that was sent. Loading received bits into the key while locked shows as one corrupted line bit damaging three output bits instead of one. A run counter that is not cleared at lock, at restart or on a zero makes the timer restart too early, so lock is held for ticks after it should have fallen. An off-by-one in the timer or in the lock count moves the edge of locked by one tick. For that reason the bench samples locked exactly one tick before and at the expected edge.

// File: rtl/desc_pkg.sv
package desc_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HELD = 1'b1
  } lock_st_e;

  // XOR of two one-based taps of a shift register image
  function automatic logic tap_pair(input logic [31:0] s,
                                    input int unsigned hi,
                                    input int unsigned lo);
    return s[hi-1] ^ s[lo-1];
  endfunction

  // true when a count sits one below its target
  function automatic logic at_last(input logic [31:0] v,
                                   input int unsigned target);
    return v == 32'(target - 1);
  endfunction

  // saturating increment toward a ceiling
  function automatic logic [31:0] sat_inc(input logic [31:0] v,
                                          input int unsigned ceil);
    return (v >= 32'(ceil)) ? v : v + 32'd1;
  endfunction

endpackage

// File: rtl/desc_keygen.sv
module desc_keygen #(
  parameter int unsigned W      = 11,
  parameter int unsigned TAP_HI = 11,
  parameter int unsigned TAP_LO = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic seed_mode,
  input  logic seed_bit,
  input  logic clear,
  output logic key_bit
);
  import desc_pkg::*;

  logic [W-1:0] st;
  logic         fb_in;

  assign key_bit = tap_pair(32'(st), TAP_HI, TAP_LO);
  assign fb_in   = seed_mode ? seed_bit : key_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) st <= '0;
    else if (adv)        st <= {st[W-2:0], fb_in};
  end
endmodule

// File: rtl/desc_runcount.sv
module desc_runcount #(
  parameter int unsigned MAXV  = 60,
  localparam int unsigned RW   = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          one_bit,
  input  logic          clear,
  output logic [RW-1:0] run
);
  import desc_pkg::*;

  logic [31:0] inc_v;
  assign inc_v = sat_inc(32'(run), MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) run <= '0;
    else if (adv) begin
      if (one_bit) run <= inc_v[RW-1:0];
      else         run <= '0;
    end
  end
endmodule

// File: rtl/desc_holdtimer.sv
module desc_holdtimer #(
  parameter int unsigned PERIOD = 90250,
  localparam int unsigned TW    = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          run_en,
  input  logic          restart,
  output logic          end_tick,
  output logic [TW-1:0] cnt
);
  import desc_pkg::*;

  logic last;
  assign last     = at_last(32'(cnt), PERIOD);
  assign end_tick = run_en && adv && last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run_en) cnt <= '0;
    else if (adv) cnt <= last ? '0 : cnt + TW'(1);
  end
endmodule

// File: rtl/idle_descrambler.sv
module idle_descrambler #(
  parameter int unsigned KEY_W       = 11,
  parameter int unsigned TAP_HI      = 11,
  parameter int unsigned TAP_LO      = 9,
  parameter int unsigned ACQ_RUN     = 60,
  parameter int unsigned HOLD_RUN    = 58,
  parameter int unsigned HOLD_CYCLES = 90250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic scr_bit,
  output logic plain_bit,
  output logic locked,
  output logic lock_lost
);
  import desc_pkg::*;

  localparam int unsigned RUN_MAX = (ACQ_RUN > HOLD_RUN) ? ACQ_RUN : HOLD_RUN;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
  localparam int unsigned TMR_W   = $clog2(HOLD_CYCLES + 1);

  lock_st_e   st_q;
  logic       key_bit;
  logic       plain_c;
  logic [RUN_W-1:0] run_cnt;
  logic [TMR_W-1:0] tmr_cnt;
  logic       tmr_end;
  logic       acq_done;
  logic       hold_ok;
  logic       expire_tick;
  logic       run_clear;

  assign locked  = (st_q == ST_HELD);
  assign plain_c = scr_bit ^ key_bit;

  // named events
  assign acq_done    = !locked && bit_en && plain_c && at_last(32'(run_cnt), ACQ_RUN);
  assign hold_ok     =  locked && bit_en && plain_c && at_last(32'(run_cnt), HOLD_RUN);
  assign expire_tick = tmr_end && !hold_ok;
  assign run_clear   = acq_done || hold_ok || expire_tick;

  desc_keygen #(.W(KEY_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (bit_en),
    .seed_mode (!locked),
    .seed_bit  (!scr_bit),
    .clear     (expire_tick),
    .key_bit   (key_bit)
  );

  desc_runcount #(.MAXV(RUN_MAX)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (bit_en),
    .one_bit (plain_c),
    .clear   (run_clear),
    .run     (run_cnt)
  );

  desc_holdtimer #(.PERIOD(HOLD_CYCLES)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (bit_en),
    .run_en   (locked),
    .restart  (acq_done || hold_ok),
    .end_tick (tmr_end),
    .cnt      (tmr_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      plain_bit <= 1'b0;
      lock_lost <= 1'b0;
    end else begin
      lock_lost <= expire_tick;
      if (bit_en) plain_bit <= plain_c;
      if (acq_done)         st_q <= ST_HELD;
      else if (expire_tick) st_q <= ST_HUNT;
    end
  end
endmodule

// File: rtl/idle_descrambler_chk.sv
module idle_descrambler_chk #(
  parameter int unsigned RUN_W  = 6,
  parameter int unsigned TMR_W  = 17,
  parameter int unsigned PERIOD = 90250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             plain_bit,
  input logic             locked,
  input logic             lock_lost,
  input logic             plain_c,
  input logic [RUN_W-1:0] run_cnt,
  input logic [TMR_W-1:0] tmr_cnt,
  input logic             acq_done,
  input logic             expire_tick
);
  // R8
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> !lock_lost);
  // R8
  lost_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> (!locked && $past(locked)));
  // R9
  idle_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(plain_bit) && $stable(locked)));
  // R6
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cnt < TMR_W'(PERIOD));
  // R7
  run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !plain_c) |=> (run_cnt == '0));
  // R4
  acq_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> locked);
  // R6
  expire_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_tick |-> locked);
endmodule

bind idle_descrambler idle_descrambler_chk #(
  .RUN_W(RUN_W), .TMR_W(TMR_W), .PERIOD(HOLD_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .plain_bit   (plain_bit),
  .locked      (locked),
  .lock_lost   (lock_lost),
  .plain_c     (plain_c),
  .run_cnt     (run_cnt),
  .tmr_cnt     (tmr_cnt),
  .acq_done    (acq_done),
  .expire_tick (expire_tick)
);

// File: tb/idle_descrambler_bench.sv
module idle_descrambler_bench;
  localparam int HOLD = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic scr_bit = 1'b0;
  logic plain_bit, locked, lock_lost;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [10:0] far_key = '0;

  always #5 clk = ~clk;

  idle_descrambler #(.HOLD_CYCLES(HOLD)) u_idle_descrambler (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .scr_bit(scr_bit),
    .plain_bit(plain_bit), .locked(locked), .lock_lost(lock_lost)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; scr_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // far-end scrambler: next key = bit 11 back XOR bit 9 back
  task automatic tx(input logic d, input logic flip);
    logic k;
    @(negedge clk);
    k = far_key[10] ^ far_key[8];
    scr_bit = d ^ k ^ flip;
    bit_en = 1'b1;
    far_key = {far_key[9:0], k};
    @(posedge clk);
    #1;
  endtask

  // sends idle until lock; returns number of bits used
  task automatic acquire(output int n);
    n = 0;
    while (!locked && n < 200) begin
      tx(1'b1, 1'b0);
      n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 locked after reset", locked, 0);
    check("R1 lock_lost after reset", lock_lost, 0);
    check("R1 plain_bit after reset", plain_bit, 0);
  endtask

  task automatic t_exact_lock();
    do_reset();
    far_key = '0;
    for (int i = 0; i < 59; i++) tx(1'b1, 1'b0);
    check("R4 still hunting at bit 59", locked, 0);
    tx(1'b1, 1'b0);
    check("R4 locked at bit 60", locked, 1);
    check("R4 plain_bit one at lock", plain_bit, 1);
  endtask

  task automatic t_gap_freeze();
    logic held;
    do_reset();
    far_key = '0;
    for (int i = 0; i < 60; i++) tx(1'b1, 1'b0);
    for (int i = 0; i < 150; i++) tx(1'b0, 1'b0);
    held = plain_bit;
    @(negedge clk);
    bit_en = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      scr_bit = ~scr_bit;
    end
    #1;
    check("R9 plain_bit frozen without bit_en", plain_bit, held);
    check("R9 locked frozen without bit_en", locked, 1);
    for (int i = 0; i < 49; i++) tx(1'b0, 1'b0);
    check("R9 timer paused, still locked at tick 199", locked, 1);
    tx(1'b0, 1'b0);
    check("R6 lock drops at tick 200", locked, 0);
  endtask

  task automatic t_seeded_data();
    int n;
    logic d;
    int bad;
    do_reset();
    far_key = 11'h5A3;
    acquire(n);
    check("R3 seeded lock not before bit 60", (n >= 60) ? 1 : 0, 1);
    check("R4 seeded lock by bit 71", (n <= 71) ? 1 : 0, 1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      d = logic'((i * 7 + i / 3) % 2);
      tx(d, 1'b0);
      if (plain_bit !== d) bad++;
    end
    check("R2 data recovered while locked (mismatches)", bad, 0);
  endtask

  task automatic t_free_run();
    int bad;
    int n;
    do_reset();
    far_key = 11'h2C7;
    acquire(n);
    check("R5 lock before corruption test", locked, 1);
    tx(1'b0, 1'b1);
    check("R5 corrupted bit shows once", plain_bit, 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tx(1'b0, 1'b0);
      if (plain_bit !== 1'b0) bad++;
    end
    check("R5 bits after corruption clean (mismatches)", bad, 0);
  endtask

  task automatic t_expiry();
    int n;
    do_reset();
    far_key = 11'h0F1;
    acquire(n);
    for (int i = 0; i < HOLD - 1; i++) tx(1'b0, 1'b0);
    check("R6 locked at tick 199", locked, 1);
    check("R8 no pulse before expiry", lock_lost, 0);
    tx(1'b0, 1'b0);
    check("R6 unlocked at tick 200", locked, 0);
    check("R8 lock_lost with fall", lock_lost, 1);
    tx(1'b1, 1'b0);
    check("R8 lock_lost lasts one clock", lock_lost, 0);
    acquire(n);
    n++;
    check("R8 relock needs new run of 60", (n >= 60) ? 1 : 0, 1);
    check("R8 relock within 71", (n <= 71) ? 1 : 0, 1);
  endtask

  task automatic t_restart();
    int n;
    do_reset();
    far_key = 11'h3B5;
    acquire(n);
    for (int i = 0; i < 57; i++) tx(1'b1, 1'b0);
    tx(1'b0, 1'b0);
    for (int i = 0; i < 57; i++) tx(1'b1, 1'b0);
    tx(1'b0, 1'b0);
    for (int i = 0; i < 83; i++) tx(1'b0, 1'b0);
    check("R7 broken runs keep lock to tick 199", locked, 1);
    tx(1'b0, 1'b0);
    check("R7 broken runs give no restart", locked, 0);
    acquire(n);
    for (int i = 0; i < 100; i++) tx(1'b0, 1'b0);
    for (int i = 0; i < 58; i++) tx(1'b1, 1'b0);
    for (int i = 0; i < 42; i++) tx(1'b0, 1'b0);
    check("R7 restart keeps lock past first period", locked, 1);
    for (int i = 0; i < 157; i++) tx(1'b0, 1'b0);
    check("R7 locked at tick 199 of new period", locked, 1);
    tx(1'b0, 1'b0);
    check("R7 new period expires at tick 200", locked, 0);
  endtask

  initial begin
    t_reset();
    t_exact_lock();
    t_gap_freeze();
    t_seeded_data();
    t_free_run();
    t_expiry();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule